// File: doc/BRIEF.md
# Cascadable Magnitude Comparator Chain

This block decides how two unsigned operands of a configurable width relate to each other. It reports exactly one of three verdicts: A above B, A equal to B, or A below B. The operands are cut into 4-bit nibbles, and each nibble goes to an identical comparator slice. Each slice takes a three-wire verdict from the slice below it. It passes that verdict on only when its own two nibbles match. When its nibbles differ, it overrides the verdict with its own result.

The least significant slice starts from a fixed seed of "equal", with "above" and "below" both clear. The verdict from the most significant slice is the final result. The block is purely combinational, and the operand width must be a non-zero multiple of four; any other width stops elaboration.

Top module: `mag_cmp_chain`

## Requirements
- R1: `a_gt_b` is 1 exactly when `opa` is greater than `opb`, with both read as unsigned numbers over the full width.
- R2: `a_eq_b` is 1 exactly when every bit of `opa` equals the same bit of `opb`.
- R3: `a_lt_b` is 1 exactly when `opa` is less than `opb`, with both read as unsigned numbers.
- R4: For every operand pair, exactly one of `a_gt_b`, `a_eq_b`, `a_lt_b` is 1.
- R5: When the most significant nibbles of the two operands differ, those nibbles alone set the verdict, whatever the lower bits hold.
- R6: The verdict passed between slices has exactly one of its three wires high at every stage, starting from the seed of "equal" at the lowest slice.
- R7: Operands that differ only in bit 0 give `a_gt_b` = 1 when `opa` holds the 1 and `a_lt_b` = 1 when `opb` holds it.
- R8: Operands that are both all-zeros or both all-ones give `a_eq_b` = 1. The all-ones value against all-zeros gives `a_gt_b` = 1, and the reverse gives `a_lt_b` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First unsigned operand |
| opb | input | WIDTH | Second unsigned operand |
| a_gt_b | output | 1 | High when opa is above opb |
| a_eq_b | output | 1 | High when opa matches opb |
| a_lt_b | output | 1 | High when opa is below opb |

## Verification
The bench builds two copies of the block. The first uses an 8-bit width, which makes two slices, and every one of the 65,536 operand pairs is applied to it. This exercises every way the upper slice can override or pass on the lower slice's verdict. The second uses a 32-bit width, which makes eight slices. It receives random pairs and pairs built to differ only in bit 0 or only in a chosen nibble, so that a difference has to travel through a long run of matching slices before it reaches the output.

// File: rtl/magcmp_pkg.sv
// Shared definitions for the cascadable magnitude comparator.
// Assumes: slices are always four bits wide; verdicts are one-hot encoded.
package magcmp_pkg;

    localparam int NIB_W = 4;

    // Three-wire verdict carried between slices.
    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } verdict_t;

    // Verdict fed into the least significant slice: operands so far are equal.
    localparam verdict_t SEED_VERDICT = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

endpackage

// File: rtl/nibble_order.sv
// Orders two nibbles on their own, ignoring any other slice.
// Assumes: unsigned operands; the most significant differing bit decides.
module nibble_order
    import magcmp_pkg::*;
(
    input  logic [NIB_W-1:0] a,
    input  logic [NIB_W-1:0] b,
    output verdict_t         order
);

    // Scan from the top bit down and let the first mismatch decide.
    always_comb begin
        logic found;
        found = 1'b0;
        order = '0;
        for (int i = NIB_W - 1; i >= 0; i--) begin
            if (!found && (a[i] != b[i])) begin
                found    = 1'b1;
                order.gt = a[i];
                order.lt = b[i];
            end
        end
        order.eq = !found;
    end

endmodule

// File: rtl/cmp_slice.sv
// One comparator slice: orders its nibble pair and merges the result with
// the verdict arriving from the less significant side.
// Assumes: cas_in is one-hot; the local order overrides it unless nibbles match.
module cmp_slice
    import magcmp_pkg::*;
(
    input  logic [NIB_W-1:0] a,
    input  logic [NIB_W-1:0] b,
    input  verdict_t         cas_in,
    output verdict_t         cas_out
);

    verdict_t local_order;

    nibble_order u_order (
        .a     (a),
        .b     (b),
        .order (local_order)
    );

    // Pass the lower verdict through only where the nibbles match.
    always_comb begin
        cas_out.gt = local_order.gt | (local_order.eq & cas_in.gt);
        cas_out.eq = local_order.eq & cas_in.eq;
        cas_out.lt = local_order.lt | (local_order.eq & cas_in.lt);
    end

endmodule

// File: rtl/mag_cmp_chain.sv
// Unsigned magnitude comparator of WIDTH bits made from a ripple chain of
// 4-bit slices, least significant slice first.
// Assumes: WIDTH is a non-zero multiple of four (checked at elaboration).
module mag_cmp_chain
    import magcmp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic             a_gt_b,
    output logic             a_eq_b,
    output logic             a_lt_b
);

    localparam int NSLICE = WIDTH / NIB_W;

    // Reject widths that cannot be cut into whole nibbles.
    generate
        if ((WIDTH % NIB_W) != 0 || WIDTH < NIB_W) begin : g_bad_width
            $fatal(1, "mag_cmp_chain: WIDTH must be a non-zero multiple of 4");
        end
    endgenerate

    // chain[0] is the seed; chain[s+1] is the verdict out of slice s.
    verdict_t [NSLICE:0] chain;

    assign chain[0] = SEED_VERDICT;

    // One slice per nibble, each fed by the slice below it.
    generate
        for (genvar s = 0; s < NSLICE; s++) begin : g_slice
            cmp_slice u_slice (
                .a       (opa[s*NIB_W +: NIB_W]),
                .b       (opb[s*NIB_W +: NIB_W]),
                .cas_in  (chain[s]),
                .cas_out (chain[s+1])
            );
        end
    endgenerate

    // Final verdict comes from the most significant slice.
    always_comb begin
        a_gt_b = chain[NSLICE].gt;
        a_eq_b = chain[NSLICE].eq;
        a_lt_b = chain[NSLICE].lt;
    end

endmodule

// File: rtl/mag_cmp_chain_chk.sv
// Assertion checker for mag_cmp_chain, attached by bind below.
// Assumes: inputs are the top's ports and its internal slice chain.
module mag_cmp_chain_chk
    import magcmp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0]              opa,
    input logic [WIDTH-1:0]              opb,
    input logic                          a_gt_b,
    input logic                          a_eq_b,
    input logic                          a_lt_b,
    input verdict_t [WIDTH/NIB_W:0]      stage
);

    localparam int NS = WIDTH / NIB_W;

    // Compare the outputs against native relational operators.
    always_comb begin
        AST_GT_MATCH: assert (a_gt_b == (opa > opb)) else $error("gt mismatch");   // R1
        AST_EQ_MATCH: assert (a_eq_b == (opa == opb)) else $error("eq mismatch");  // R2
        AST_LT_MATCH: assert (a_lt_b == (opa < opb)) else $error("lt mismatch");   // R3
        AST_ONE_VERDICT: assert ($countones({a_gt_b, a_eq_b, a_lt_b}) == 1) else $error("not one-hot"); // R4
        if (opa[WIDTH-1 -: NIB_W] != opb[WIDTH-1 -: NIB_W]) begin
            AST_TOP_NIBBLE_RULES: assert (a_gt_b == (opa[WIDTH-1 -: NIB_W] > opb[WIDTH-1 -: NIB_W])) else $error("top nibble ignored"); // R5
        end
    end

    // Every verdict on the chain must be one-hot.
    always_comb begin
        for (int k = 0; k <= NS; k++) begin
            AST_STAGE_ONEHOT: assert ($onehot(stage[k])) else $error("stage not one-hot"); // R6
        end
    end

endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(.WIDTH(WIDTH)) u_chk (
    .opa    (opa),
    .opb    (opb),
    .a_gt_b (a_gt_b),
    .a_eq_b (a_eq_b),
    .a_lt_b (a_lt_b),
    .stage  (chain)
);

// File: tb/sim_mag_cmp_chain.sv
// Self-checking bench: exhaustive at 8 bits, random plus directed at 32 bits.
module sim_mag_cmp_chain;

    localparam int SW = 8;
    localparam int WW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [SW-1:0] sa, sb;
    logic          s_gt, s_eq, s_lt;
    logic [WW-1:0] wa, wb;
    logic          w_gt, w_eq, w_lt;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    mag_cmp_chain #(.WIDTH(SW)) u0 (
        .opa(sa), .opb(sb), .a_gt_b(s_gt), .a_eq_b(s_eq), .a_lt_b(s_lt)
    );

    mag_cmp_chain #(.WIDTH(WW)) u1 (
        .opa(wa), .opb(wb), .a_gt_b(w_gt), .a_eq_b(w_eq), .a_lt_b(w_lt)
    );

    // Compare one verdict triple with the expected one.
    task automatic judge(input string req, input logic [2:0] got, input logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got gt/eq/lt=%b expected %b", req, got, exp);
        end
    endtask

    // Apply a pair to the 8-bit copy and check it at the falling edge.
    task automatic run_small(input string req, input logic [SW-1:0] a, input logic [SW-1:0] b);
        @(posedge clk);
        sa = a; sb = b;
        @(negedge clk);
        judge(req, {s_gt, s_eq, s_lt}, {a > b, a == b, a < b});
    endtask

    // Apply a pair to the 32-bit copy and check it at the falling edge.
    task automatic run_wide(input string req, input logic [WW-1:0] a, input logic [WW-1:0] b);
        @(posedge clk);
        wa = a; wb = b;
        @(negedge clk);
        judge(req, {w_gt, w_eq, w_lt}, {a > b, a == b, a < b});
    endtask

    initial begin
        sa = '0; sb = '0; wa = '0; wb = '0;
        repeat (3) @(posedge clk);
        // Reset state: zero operands give "equal" on both copies (R8).
        @(negedge clk);
        judge("R8 reset-zero small", {s_gt, s_eq, s_lt}, 3'b010);
        judge("R8 reset-zero wide", {w_gt, w_eq, w_lt}, 3'b010);
        rst_n = 1'b1;

        // Boundary values (R8).
        run_small("R8 ones-ones", '1, '1);
        run_small("R8 ones-zero", '1, '0);
        run_small("R8 zero-ones", '0, '1);
        run_wide("R8 ones-ones", '1, '1);
        run_wide("R8 ones-zero", '1, '0);
        run_wide("R8 zero-ones", '0, '1);

        // Bit-0-only differences (R7).
        run_small("R7 lsb a", 8'h81, 8'h80);
        run_small("R7 lsb b", 8'h80, 8'h81);
        run_wide("R7 lsb a", 32'hA5A5_0001, 32'hA5A5_0000);
        run_wide("R7 lsb b", 32'hFFFF_FFFE, 32'hFFFF_FFFF);

        // Top nibble overrides lower nibbles (R5).
        run_small("R5 top wins gt", 8'h20, 8'h1F);
        run_small("R5 top wins lt", 8'h1F, 8'h20);
        run_wide("R5 top wins gt", 32'h8000_0000, 32'h7FFF_FFFF);
        run_wide("R5 top wins lt", 32'h7FFF_FFFF, 32'h8000_0000);

        // One differing nibble at each position of the wide copy (R6).
        for (int n = 0; n < WW / 4; n++) begin
            run_wide("R6 single nibble", 32'h5555_5555 | (32'h8 << (4 * n)), 32'h5555_5555);
            run_wide("R6 single nibble", 32'h5555_5555, 32'h5555_5555 | (32'h8 << (4 * n)));
        end

        // Exhaustive sweep of the 8-bit copy (R1 R2 R3 R4).
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                run_small("R1 R2 R3 R4 sweep", i[SW-1:0], j[SW-1:0]);
            end
        end

        // Random pairs on the 32-bit copy, some with equal high halves (R1 R2 R3).
        for (int k = 0; k < 3000; k++) begin
            logic [WW-1:0] ra, rb;
            ra = $urandom;
            rb = (k % 3 == 0) ? {ra[WW-1:16], 16'($urandom)} : $urandom;
            if (k % 7 == 0) rb = ra;
            run_wide("R1 R2 R3 random", ra, rb);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule